// File: doc/BRIEF.md
# DMA Page Address Generator

This block sits beside a cascaded pair of 8-bit DMA controllers and turns their 16-bit transfer offsets into 24-bit system-memory addresses. A bank of sixteen 8-bit page registers, written and read over a small I/O port, provides the upper address bits. Each DMA channel takes its page from a fixed register index, and the channel-to-index mapping is irregular.

Channels 0 to 3 move bytes. Channels 5 to 7 move 16-bit words. For a word channel the page LSB is dropped and the offset is shifted up by one, so the address counts words. Channel 4 is the cascade link and has no page. Word transfers still pass through an 8-bit DMA data path. A high-byte latch captures the upper half of each word read and supplies the upper half of each word write. The block tracks which channel holds its acknowledge asserted, gates memory strobes on that, and steers end-of-process to a per-channel terminal-count line.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset every page register reads 0, no channel is active (tc is all zero, mem_re and mem_we stay low), and the high-byte latch holds 0xFF.
- R2: A cycle with io_wr high stores io_wdata in page register io_addr. io_rdata always shows register io_addr, combinationally.
- R3: The page register index used for each channel is: ch0→7, ch1→3, ch2→1, ch3→2, ch5→11, ch6→9, ch7→10.
- R4: While byte channel 0–3 is active, mem_addr = page·65536 + dma_off and mem_word = 0.
- R5: While word channel 5–7 is active, mem_addr = ((page AND 0xFE)·65536) OR (dma_off·2) truncated to 24 bits, and mem_word = 1.
- R6: While channel 4 is active, mem_addr = 0xFF0000 for any offset and mem_word = 0.
- R7: A falling edge on ack_n[c] makes channel c active from the next cycle. A rising edge on ack_n[c] clears the active channel only if c is the active channel. Otherwise it has no effect.
- R8: With no active channel, dma_rdata = 0xFF and mem_re and mem_we stay low even when dma_rd or dma_wr is high. With an active channel, mem_re = dma_rd, mem_we = dma_wr, and dma_rdata = mem_rdata[7:0].
- R9: A read on a word channel loads mem_rdata[15:8] into the high-byte latch at the clock edge. A write outputs mem_wdata = {latch, dma_wdata} on a word channel and {0x00, dma_wdata} on a byte channel.
- R10: tc has bit c set exactly when channel c is active and eop is high, so tc rises or falls on activation or release while eop is already high.
- R11: When several ack_n edges arrive in the same cycle, they are applied in ascending channel order, so the highest falling channel becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Page register write strobe |
| io_addr | input | 4 | Page register index |
| io_wdata | input | 8 | Page register write data |
| io_rdata | output | 8 | Page register read data |
| ack_n | input | 8 | Per-channel active-low acknowledge |
| eop | input | 1 | End-of-process from the controllers |
| tc | output | 8 | Per-channel terminal count |
| dma_off | input | 16 | Transfer offset from the controller |
| dma_rd | input | 1 | Memory read request |
| dma_rdata | output | 8 | Read data to the 8-bit DMA path |
| dma_wr | input | 1 | Memory write request |
| dma_wdata | input | 8 | Write data from the 8-bit DMA path |
| mem_addr | output | 24 | System memory byte address |
| mem_word | output | 1 | 1 for a 16-bit access |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data |
| mem_wdata | output | 16 | Memory write data |

## Verification
The page bank is filled with a pattern in which odd and even values alternate, so the word-channel LSB drop shows up as a difference. Every channel, including channel 4, is then swept across offsets 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF. A wrong register index, a missing shift or a carry into the page separates from the correct address at one of these points. Acknowledge sequences cover nested activation, release by a channel that is not active, and simultaneous edges, which tells the release rule apart from a plain "last edge wins" rule. Word read-then-write pairs with distinct byte halves, plus a word write made before any read, show whether the latch carries the reset value or the read value into the right byte lane.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int NUM_CH   = 8;
  localparam int NUM_PG   = 16;
  localparam int PG_W     = 8;
  localparam int OFF_W    = 16;
  localparam int ADDR_W   = PG_W + OFF_W;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int PGI_W    = $clog2(NUM_PG);
  localparam int CASC_CH  = NUM_CH / 2;

  // channel to page register index (irregular legacy map)
  function automatic logic [PGI_W-1:0] page_index(input logic [CH_W-1:0] ch);
    logic [PGI_W-1:0] idx;
    case (ch)
      3'd0:    idx = 4'd7;
      3'd1:    idx = 4'd3;
      3'd2:    idx = 4'd1;
      3'd3:    idx = 4'd2;
      3'd5:    idx = 4'd11;
      3'd6:    idx = 4'd9;
      3'd7:    idx = 4'd10;
      default: idx = 4'd0;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/dpg_page_bank.sv
module dpg_page_bank #(
  parameter int NUM   = 16,
  parameter int W     = 8,
  localparam int IW   = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] pages [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic         en;
    logic [W-1:0] nxt;
    always_comb begin
      en  = wr && (waddr == IW'(g));
      nxt = en ? wdata : pages[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pages[g] <= '0;
      else        pages[g] <= nxt;
    end
  end

  assign rdata_a = pages[raddr_a];
  assign rdata_b = pages[raddr_b];

  // R2
  page_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> pages[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dpg_chan_track.sv
module dpg_chan_track #(
  parameter int NCH  = 8,
  localparam int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ack_n,
  input  logic           eop,
  output logic           act_vld,
  output logic [CW-1:0]  act_ch,
  output logic [NCH-1:0] tc
);
  logic [NCH-1:0] ack_q;
  logic           vld_nxt;
  logic [CW-1:0]  ch_nxt;

  always_comb begin
    vld_nxt = act_vld;
    ch_nxt  = act_ch;
    for (int c = 0; c < NCH; c++) begin
      if (ack_q[c] && !ack_n[c]) begin
        vld_nxt = 1'b1;
        ch_nxt  = CW'(c);
      end else if (!ack_q[c] && ack_n[c] && vld_nxt && (ch_nxt == CW'(c))) begin
        vld_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= '1;
      act_vld <= 1'b0;
      act_ch  <= '0;
    end else begin
      ack_q   <= ack_n;
      act_vld <= vld_nxt;
      act_ch  <= ch_nxt;
    end
  end

  always_comb begin
    tc = '0;
    if (act_vld && eop) tc[act_ch] = 1'b1;
  end

  // R10
  tc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tc));
  // R7
  fall_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q[0] && !ack_n[0] && (ack_n[NCH-1:1] == ack_q[NCH-1:1])) |=> (act_vld && act_ch == '0));
endmodule

// File: rtl/dpg_addr_form.sv
module dpg_addr_form #(
  parameter int PW    = 8,
  parameter int OW    = 16,
  parameter int NCH   = 8,
  localparam int AW   = PW + OW,
  localparam int CW   = $clog2(NCH),
  localparam int CASC = NCH / 2
) (
  input  logic          vld,
  input  logic [CW-1:0] ch,
  input  logic [PW-1:0] page,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] addr,
  output logic          word
);
  always_comb begin
    word = 1'b0;
    addr = '0;
    if (vld) begin
      if (ch == CW'(CASC)) begin
        addr = {{PW{1'b1}}, {OW{1'b0}}};
      end else if (ch > CW'(CASC)) begin
        word = 1'b1;
        addr = {page[PW-1:1], off, 1'b0};
      end else begin
        addr = {page, off};
      end
    end
  end
endmodule

// File: rtl/dma_page_xlate.sv
module dma_page_xlate
  import dpg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_wr,
  input  logic [PGI_W-1:0]    io_addr,
  input  logic [PG_W-1:0]     io_wdata,
  output logic [PG_W-1:0]     io_rdata,
  input  logic [NUM_CH-1:0]   ack_n,
  input  logic                eop,
  output logic [NUM_CH-1:0]   tc,
  input  logic [OFF_W-1:0]    dma_off,
  input  logic                dma_rd,
  output logic [7:0]          dma_rdata,
  input  logic                dma_wr,
  input  logic [7:0]          dma_wdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_word,
  output logic                mem_re,
  output logic                mem_we,
  input  logic [15:0]         mem_rdata,
  output logic [15:0]         mem_wdata
);
  logic            act_vld;
  logic [CH_W-1:0] act_ch;
  logic [PG_W-1:0] act_page;
  logic [7:0]      hi_q, hi_nxt;
  logic            hi_en;

  dpg_page_bank #(.NUM(NUM_PG), .W(PG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .waddr(io_addr), .wdata(io_wdata),
    .raddr_a(io_addr), .rdata_a(io_rdata),
    .raddr_b(page_index(act_ch)), .rdata_b(act_page)
  );

  dpg_chan_track #(.NCH(NUM_CH)) u_track (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .eop(eop),
    .act_vld(act_vld), .act_ch(act_ch), .tc(tc)
  );

  dpg_addr_form #(.PW(PG_W), .OW(OFF_W), .NCH(NUM_CH)) u_form (
    .vld(act_vld), .ch(act_ch), .page(act_page), .off(dma_off),
    .addr(mem_addr), .word(mem_word)
  );

  always_comb begin
    mem_re    = dma_rd && act_vld;
    mem_we    = dma_wr && act_vld;
    dma_rdata = act_vld ? mem_rdata[7:0] : 8'hFF;
    mem_wdata = {mem_word ? hi_q : 8'h00, dma_wdata};
    hi_en     = mem_re && mem_word;
    hi_nxt    = hi_en ? mem_rdata[15:8] : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 8'hFF;
    else        hi_q <= hi_nxt;
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc == '0 && !act_vld) |-> (!mem_re && !mem_we));
  // R9
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_word) |=> hi_q == $past(mem_rdata[15:8]));
  // R5
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_word |-> !mem_addr[0]);
  // R6
  casc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && act_ch == CH_W'(CASC_CH)) |-> (mem_addr[OFF_W-1:0] == '0 && !mem_word));
endmodule

// File: tb/dma_page_xlate_tb.sv
module dma_page_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [3:0]  io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic [7:0]  ack_n;
  logic        eop;
  logic [7:0]  tc;
  logic [15:0] dma_off;
  logic        dma_rd, dma_wr;
  logic [7:0]  dma_rdata, dma_wdata;
  logic [23:0] mem_addr;
  logic        mem_word, mem_re, mem_we;
  logic [15:0] mem_rdata, mem_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .ack_n(ack_n), .eop(eop), .tc(tc), .dma_off(dma_off),
    .dma_rd(dma_rd), .dma_rdata(dma_rdata), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .mem_addr(mem_addr), .mem_word(mem_word), .mem_re(mem_re), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pidx(input int ch);
    case (ch)
      0: return 7;  1: return 3;  2: return 1;  3: return 2;
      5: return 11; 6: return 9;  7: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] pval(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic ack_set(input int ch, input logic v);
    @(negedge clk);
    ack_n[ch] = v;
    @(negedge clk);
  endtask

  logic [15:0] offs [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_wr = 0; io_addr = 0; io_wdata = 0; ack_n = '1; eop = 0;
    dma_off = 0; dma_rd = 0; dma_wr = 0; dma_wdata = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      io_addr = 4'(i); #1;
      chk("R1 page reset", io_rdata, 0);
    end
    eop = 1; dma_rd = 1; dma_wr = 1; #1;
    chk("R1 tc idle", tc, 0);
    chk("R8 re idle", mem_re, 0);
    chk("R8 we idle", mem_we, 0);
    chk("R8 rdata idle", dma_rdata, 8'hFF);
    eop = 0; dma_rd = 0; dma_wr = 0;

    // R2 fill and read back
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      io_wr = 1; io_addr = 4'(i); io_wdata = pval(i);
    end
    @(negedge clk);
    io_wr = 0;
    for (int i = 0; i < 16; i++) begin
      io_addr = 4'(i); #1;
      chk("R2 readback", io_rdata, pval(i));
    end

    // R1 latch reset value, observed through a word write before any read
    ack_set(6, 1'b0);
    dma_wr = 1; dma_wdata = 8'h3C; #1;
    chk("R1 latch reset", mem_wdata, 16'hFF3C);
    chk("R8 we active", mem_we, 1);
    dma_wr = 0;
    ack_set(6, 1'b1);

    // R3 R4 R5 R6 address sweep
    for (int ch = 0; ch < 8; ch++) begin
      ack_set(ch, 1'b0);
      for (int k = 0; k < 5; k++) begin
        logic [31:0] pg, ea;
        dma_off = offs[k]; #1;
        pg = 32'(pval(pidx(ch)));
        if (ch == 4) begin
          ea = 32'hFF0000;
          chk("R6 cascade addr", mem_addr, ea);
          chk("R6 cascade size", mem_word, 0);
        end else if (ch > 4) begin
          ea = (((pg & 32'hFE) << 16) | (32'(offs[k]) << 1)) & 32'hFFFFFF;
          chk("R3 R5 word addr", mem_addr, ea);
          chk("R5 word size", mem_word, 1);
        end else begin
          ea = (pg << 16) + 32'(offs[k]);
          chk("R3 R4 byte addr", mem_addr, ea);
          chk("R4 byte size", mem_word, 0);
        end
      end
      ack_set(ch, 1'b1);
      chk("R7 release", mem_re | mem_we | tc, 0);
    end

    // R9 word read latch then write combine
    ack_set(5, 1'b0);
    @(negedge clk);
    mem_rdata = 16'hA55A; dma_rd = 1; #1;
    chk("R8 rdata active", dma_rdata, 8'h5A);
    chk("R8 re active", mem_re, 1);
    @(negedge clk);
    dma_rd = 0; mem_rdata = 16'h0000; dma_wr = 1; dma_wdata = 8'h3C; #1;
    chk("R9 word write", mem_wdata, 16'hA53C);
    dma_wr = 0;
    ack_set(5, 1'b1);
    ack_set(1, 1'b0);
    @(negedge clk);
    mem_rdata = 16'h7711; dma_rd = 1;
    @(negedge clk);
    dma_rd = 0; dma_wr = 1; dma_wdata = 8'h99; #1;
    chk("R9 byte write", mem_wdata, 16'h0099);
    dma_wr = 0;
    ack_set(1, 1'b1);
    ack_set(6, 1'b0);
    dma_wr = 1; dma_wdata = 8'h01; #1;
    chk("R9 byte read no latch", mem_wdata, 16'hA501);
    dma_wr = 0;
    ack_set(6, 1'b1);

    // R7 release by a non-active channel is ignored
    ack_set(3, 1'b0);
    ack_set(2, 1'b0);
    ack_set(3, 1'b1);
    eop = 1; #1;
    chk("R7 other release ignored", tc, 8'h04);
    ack_set(2, 1'b1);
    chk("R10 tc drops on release", tc, 8'h00);

    // R10 eop already high at activation
    ack_set(7, 1'b0);
    chk("R10 tc raised on activation", tc, 8'h80);
    eop = 0; #1;
    chk("R10 tc follows eop", tc, 8'h00);
    ack_set(7, 1'b1);

    // R11 simultaneous edges
    @(negedge clk);
    ack_n[1] = 0; ack_n[3] = 0;
    @(negedge clk);
    eop = 1; #1;
    chk("R11 highest wins", tc, 8'h08);
    @(negedge clk);
    ack_n[1] = 1; ack_n[3] = 1;
    @(negedge clk); #1;
    chk("R11 release both", tc, 8'h00);
    eop = 0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule